// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for an external Ethernet PHY. Software reaches it through a small register port that holds two 32-bit registers. The location register carries the target port address, device address and register address. The command register carries the operation code, a 16-bit payload, an MDC rate select, a spare control flag and a busy flag. Software writes the location register first. It then writes the command register with busy set, and that write starts the transaction.

A transaction always has two frames. The first is an address frame that loads the target register address into the PHY. The second is a data frame that either writes the payload or reads a value back. The block generates MDC by dividing the system clock. It shifts each frame out MSB first, and it changes MDIO only while MDC is low. On a read it releases the MDIO line from the start of the turnaround onwards and samples the returned bits on MDC rising edges. When the data frame ends, the busy flag clears and the result appears in the payload field. Software polls the command register to see when the transaction is done.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset both registers read as zero, MDC is low, the output enable is low and the MDIO output is high.
- R2: The location register (`reg_sel`=0) holds the register address in bits [15:0], the port address in bits [20:16] and the device address in bits [25:21]. Bits [31:26] read as zero.
- R3: The command register (`reg_sel`=1) holds the payload in [15:0], the opcode in [17:16] (0 none, 1 write, 2 read with post-increment, 3 read), a spare flag in [18], the rate select in [21:19] and busy in [22]. Bits [31:23] read as zero. A write while idle stores all fields. Busy reads 1 from the cycle after a launching write until the transaction ends.
- R4: Every transaction begins with an address frame: 32 ones, then 00, 00, the 5-bit port, the 5-bit device, 10, and the 16-bit register address, all MSB first. A transaction is 128 MDC rising edges long.
- R5: The data frame follows the address frame. It has 32 ones, then 00, then the frame opcode (01 write, 10 read with post-increment, 11 read), the port, the device, 10, and for a write the 16-bit payload.
- R6: For a read, the output enable is low from bit 46 of the data frame (the first turnaround bit) to the end of the frame. The 16 bits driven by the PHY are sampled MSB first on MDC rising edges and appear in command bits [15:0] when busy clears.
- R7: The MDC period is 2^(select+3) system clocks. MDC stays low while no transaction runs.
- R8: The MDIO output never changes while MDC is high.
- R9: While busy, a write to the command register has no effect: it neither starts a transaction nor changes any field or the frame in flight.
- R10: The device, port and register addresses are captured when a transaction launches. Writing the location register during a transaction changes its readback but not the frames.
- R11: A command write with busy set and opcode 0 stores its fields. It creates no MDC activity, and busy reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 location, 1 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
If the frame engine's bit counter or phase drifts, the error shows within one MDC period. The captured bit stream no longer matches the computed frames, or the transaction takes a number of rising edges other than 128. A wrong divider state shows as soon as the second MDC rising edge, because the spacing between rising edges changes. A busy flag that fails to block a command write appears one cycle after that write, as a changed field in the command readback. It can also appear later, as a frame built from the intruding opcode or payload. A fault in read capture shows only when busy clears, as a wrong payload field. The bench therefore compares the payload with the pattern its PHY model drove.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    OPC_NONE     = 2'd0,
    OPC_WRITE    = 2'd1,
    OPC_RD_INC   = 2'd2,
    OPC_READ     = 2'd3
  } mdio_opc_e;

  // command register field positions (software visible)
  localparam int unsigned CF_DATA_LO = 0;
  localparam int unsigned CF_OPC_LO  = 16;
  localparam int unsigned CF_AUX     = 18;
  localparam int unsigned CF_SEL_LO  = 19;
  localparam int unsigned CF_BUSY    = 22;

  // location register field positions
  localparam int unsigned LF_PORT_LO = 16;
  localparam int unsigned LF_DEV_LO  = 21;

  // opcode carried in the second frame
  function automatic logic [1:0] frame_opc(input logic [1:0] opc);
    case (opc)
      OPC_WRITE:  frame_opc = 2'b01;
      OPC_RD_INC: frame_opc = 2'b10;
      OPC_READ:   frame_opc = 2'b11;
      default:    frame_opc = 2'b00;
    endcase
  endfunction

  function automatic logic opc_is_read(input logic [1:0] opc);
    opc_is_read = (opc == OPC_READ) || (opc == OPC_RD_INC);
  endfunction

  // the 32 bits that follow the preamble: ST, OP, port, device, TA, payload
  function automatic logic [31:0] frame_tail(input logic [1:0] op,
                                             input logic [4:0] port,
                                             input logic [4:0] dev,
                                             input logic [15:0] payload);
    frame_tail = {2'b00, op, port, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_BASE = 3,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
  localparam int unsigned CNT_W   = DIV_BASE + MAX_SEL;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  // half period = 2^(sel + DIV_BASE - 1) system clocks
  assign half_m1   = (CNT_W'(1) << (32'(sel) + DIV_BASE - 1)) - CNT_W'(1);
  assign wrap      = en && (cnt == half_m1);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       opc,
  input  logic [SEL_W-1:0] sel,
  input  logic [15:0]      payload,
  input  logic [4:0]       port,
  input  logic [4:0]       dev,
  input  logic [15:0]      regad,
  input  logic             mdc,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             mdio_i,
  output logic             active,
  output logic [SEL_W-1:0] sel_q,
  output logic             rd_done,
  output logic [15:0]      rd_word,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int unsigned FRAME_LEN = PRE_LEN + 32;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic [1:0]       opc_q;
  logic [15:0]      pay_q;
  logic [4:0]       port_q;
  logic [4:0]       dev_q;
  logic [15:0]      reg_q;
  logic [15:0]      rd_sh;

  logic [31:0]      tail;
  logic [4:0]       tpos;
  logic             rd_op;
  logic             released;
  logic             last_bit;
  logic             frame_done;

  assign rd_op      = opc_is_read(opc_q);
  assign tail       = (phase == PH_ADDR) ? frame_tail(2'b00, port_q, dev_q, reg_q)
                                         : frame_tail(frame_opc(opc_q), port_q, dev_q, pay_q);
  assign tpos       = 5'(LAST_IDX - idx);
  assign active     = (phase != PH_IDLE);
  assign released   = (phase == PH_DATA) && rd_op && (idx >= TA_IDX);
  assign mdio_oe    = active && !released;
  assign mdio_o     = !active || (idx < PRE_IDX) || tail[tpos];
  assign last_bit   = fall_tick && (idx == LAST_IDX);
  assign frame_done = (phase == PH_DATA) && last_bit;
  assign rd_done    = frame_done && rd_op;
  assign rd_word    = rd_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      opc_q  <= '0;
      pay_q  <= '0;
      port_q <= '0;
      dev_q  <= '0;
      reg_q  <= '0;
      sel_q  <= '0;
      rd_sh  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_ADDR;
            idx    <= '0;
            opc_q  <= opc;
            pay_q  <= payload;
            port_q <= port;
            dev_q  <= dev;
            reg_q  <= regad;
            sel_q  <= sel;
            rd_sh  <= '0;
          end
        end
        PH_ADDR: begin
          if (last_bit) begin
            phase <= PH_DATA;
            idx   <= '0;
          end else if (fall_tick) begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: begin
          if (rise_tick && rd_op && (idx >= DAT_IDX))
            rd_sh <= {rd_sh[14:0], mdio_i};
          if (last_bit) begin
            phase <= PH_IDLE;
            idx   <= '0;
          end else if (fall_tick) begin
            idx <= idx + IDX_W'(1);
          end
        end
      endcase
    end
  end

  // R8
  mdio_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R6
  release_low_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && active) |-> !mdc);

  // R4
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> (active && mdio_oe && mdio_o && !mdc));

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        is_cmd,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        rd_done,
  input  logic [15:0] rd_word,
  output logic [31:0] rdata,
  output logic        launch,
  output logic [4:0]  port,
  output logic [4:0]  dev,
  output logic [15:0] regad
);
  localparam int unsigned LOC_W = LF_DEV_LO + 5;
  localparam int unsigned CMD_W = CF_BUSY + 1;

  logic [15:0]      data_q;
  logic [1:0]       opc_q;
  logic             aux_q;
  logic [SEL_W-1:0] rate_q;
  logic [LOC_W-1:0] loc_q;
  logic             cmd_accept;
  logic             unused_hi;

  assign unused_hi  = ^wdata[31:CMD_W];
  assign cmd_accept = we && is_cmd && !busy;
  assign launch     = cmd_accept && wdata[CF_BUSY] && (wdata[CF_OPC_LO +: 2] != OPC_NONE);

  assign regad = loc_q[15:0];
  assign port  = loc_q[LF_PORT_LO +: 5];
  assign dev   = loc_q[LF_DEV_LO +: 5];

  assign rdata = is_cmd ? {(32 - CMD_W)'(0), busy, rate_q, aux_q, opc_q, data_q}
                        : {(32 - LOC_W)'(0), loc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_q  <= '0;
      data_q <= '0;
      opc_q  <= '0;
      aux_q  <= 1'b0;
      rate_q <= '0;
    end else begin
      if (we && !is_cmd)
        loc_q <= wdata[LOC_W-1:0];
      if (cmd_accept) begin
        data_q <= wdata[CF_DATA_LO +: 16];
        opc_q  <= wdata[CF_OPC_LO +: 2];
        aux_q  <= wdata[CF_AUX];
        rate_q <= wdata[CF_SEL_LO +: SEL_W];
      end else if (rd_done) begin
        data_q <= rd_word;
      end
    end
  end

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && is_cmd) |=> ($stable(opc_q) && $stable(rate_q) && $stable(aux_q)));

  // R11
  noop_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_cmd && !busy && wdata[CF_BUSY] && (wdata[CF_OPC_LO +: 2] == OPC_NONE)) |=> !busy);

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_BASE = 3,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int unsigned SEL_W = 3;

  logic             launch;
  logic             busy;
  logic             rd_done;
  logic [15:0]      rd_word;
  logic [4:0]       port;
  logic [4:0]       dev;
  logic [15:0]      regad;
  logic [SEL_W-1:0] rate_run;
  logic             rise_tick;
  logic             fall_tick;

  mdio_regfile #(.SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .is_cmd  (reg_sel),
    .wdata   (reg_wdata),
    .busy    (busy),
    .rd_done (rd_done),
    .rd_word (rd_word),
    .rdata   (reg_rdata),
    .launch  (launch),
    .port    (port),
    .dev     (dev),
    .regad   (regad)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .SEL_W(SEL_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .opc       (reg_wdata[CF_OPC_LO +: 2]),
    .sel       (reg_wdata[CF_SEL_LO +: SEL_W]),
    .payload   (reg_wdata[CF_DATA_LO +: 16]),
    .port      (port),
    .dev       (dev),
    .regad     (regad),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (busy),
    .sel_q     (rate_run),
    .rd_done   (rd_done),
    .rd_word   (rd_word),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  mdio_clkgen #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .sel       (rate_run),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

endmodule

// File: tb/mdio_c45_master_test.sv
module mdio_c45_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_c45_master uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [31:0] ta;
    logic [31:0] td;
    bit          rd;
    longint      period;
    logic [31:0] cmd_exp;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0, n_bad = 0;
  int   k = 0, phy_j = 0;
  bit   cap_o[128], cap_oe[128];
  time  t0 = 0, t1 = 0;
  logic [15:0] phy_pat = '0;
  logic [31:0] obs_cmd = '0;
  int   done_cnt = 0, seen = 0;
  int   hi_glitch = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bus capture at each MDC rising edge
  always @(posedge mdc) begin
    if (k < 128) begin
      cap_o[k]  = mdio_o;
      cap_oe[k] = mdio_oe;
    end
    if (k == 0) t0 = $time;
    if (k == 1) t1 = $time;
    k++;
  end

  // PHY model: drive the read pattern while MDC is low
  always @(negedge mdc) begin
    phy_j = k - 64;
    if (phy_j >= 48 && phy_j <= 63) mdio_i <= phy_pat[63 - phy_j];
    else mdio_i <= 1'b1;
  end

  // R8 watch: output may not move while MDC stays high
  always @(negedge clk) begin
    if (rst_n && mdc && prev_mdc && (mdio_o !== prev_o)) hi_glitch++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic wr_reg(input bit s, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input bit s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input bit busy, input logic [2:0] sel, input bit aux,
                                           input logic [1:0] opc, input logic [15:0] d);
    return {9'b0, busy, sel, aux, opc, d};
  endfunction

  task automatic run_op(input logic [4:0] port, input logic [4:0] dev, input logic [15:0] ra,
                        input logic [1:0] opc, input logic [15:0] d, input logic [2:0] sel,
                        input bit aux, input logic [15:0] pat, input bit meddle, input string tag);
    exp_t e;
    logic [31:0] v;
    logic [1:0]  fop;
    fop = (opc == 2'd1) ? 2'b01 : (opc == 2'd2) ? 2'b10 : 2'b11;
    e.rd      = (opc >= 2'd2);
    e.ta      = {4'b0000, port, dev, 2'b10, ra};
    e.td      = {2'b00, fop, port, dev, 2'b10, (e.rd ? 16'h0000 : d)};
    e.period  = 20 * (64'd1 << (sel + 3));
    e.cmd_exp = cmd_word(1'b0, sel, aux, opc, e.rd ? pat : d);
    e.tag     = tag;
    sbq.push_back(e);
    wr_reg(1'b0, {6'b0, dev, port, ra});
    k = 0;
    phy_pat = pat;
    wr_reg(1'b1, cmd_word(1'b1, sel, aux, opc, d));
    rd_reg(1'b1, v);
    chk(v[22] == 1'b1, "R3 busy live during transfer", {31'b0, v[22]}, 32'd1);
    if (meddle) begin
      repeat (200) @(negedge clk);
      wr_reg(1'b1, cmd_word(1'b1, 3'd7, 1'b1, 2'd3, 16'h1111));
      wr_reg(1'b0, 32'h0155_5555);
      rd_reg(1'b0, v);
      chk(v == 32'h0155_5555, "R10 location readback changes mid transfer", v, 32'h0155_5555);
    end
    do rd_reg(1'b1, v); while (v[22]);
    obs_cmd = v;
    done_cnt++;
    wait (seen == done_cnt);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    int   bad_a, bad_d, bad_oe;
    bit   eb;
    forever begin
      wait (done_cnt > seen);
      e = sbq.pop_front();
      bad_a = 0; bad_d = 0; bad_oe = 0;
      for (int i = 0; i < 64; i++) begin
        eb = (i < 32) ? 1'b1 : e.ta[63 - i];
        if (cap_o[i] != eb) bad_a++;
        if (cap_oe[i] != 1'b1) bad_oe++;
      end
      for (int i = 0; i < 64; i++) begin
        eb = (i < 32) ? 1'b1 : e.td[63 - i];
        if (e.rd && i >= 46) begin
          if (cap_oe[64 + i] != 1'b0) bad_oe++;
        end else begin
          if (cap_o[64 + i] != eb) bad_d++;
          if (cap_oe[64 + i] != 1'b1) bad_oe++;
        end
      end
      chk(k == 128, {"R4 rising edge count ", e.tag}, k, 128);
      chk(bad_a == 0, {"R4 address frame bits ", e.tag}, bad_a, 0);
      chk(bad_d == 0, {"R5 data frame bits ", e.tag}, bad_d, 0);
      chk(bad_oe == 0, {"R6 output enable pattern ", e.tag}, bad_oe, 0);
      chk((t1 - t0) == e.period, {"R7 MDC period ", e.tag}, 32'(t1 - t0), 32'(e.period));
      chk(obs_cmd == e.cmd_exp, {e.rd ? "R6 " : "R5 ", "command readback ", e.tag}, obs_cmd, e.cmd_exp);
      seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(1'b0, v); chk(v == 32'h0, "R1 location reset", v, 32'h0);
    rd_reg(1'b1, v); chk(v == 32'h0, "R1 command reset", v, 32'h0);
    chk({mdc, mdio_oe, mdio_o} == 3'b001, "R1 bus idle pins", {29'b0, mdc, mdio_oe, mdio_o}, 32'h1);

    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, v); chk(v == 32'h03FF_FFFF, "R2 location field width", v, 32'h03FF_FFFF);

    k = 0;
    wr_reg(1'b1, cmd_word(1'b0, 3'd5, 1'b1, 2'd3, 16'hCAFE));
    rd_reg(1'b1, v);
    chk(v == cmd_word(1'b0, 3'd5, 1'b1, 2'd3, 16'hCAFE), "R3 idle store without busy", v,
        cmd_word(1'b0, 3'd5, 1'b1, 2'd3, 16'hCAFE));
    repeat (50) @(negedge clk);
    chk(k == 0 && mdc == 1'b0, "R7 MDC quiet without launch", k, 0);

    run_op(5'd5, 5'd1, 16'h1234, 2'd1, 16'hBEEF, 3'd0, 1'b0, 16'h0000, 1'b0, "write");
    run_op(5'h1F, 5'h1E, 16'h0001, 2'd3, 16'h9999, 3'd1, 1'b1, 16'hA5C3, 1'b0, "read");
    run_op(5'h0A, 5'h03, 16'h8001, 2'd2, 16'h0000, 3'd0, 1'b0, 16'h0F0F, 1'b0, "post-inc read");
    // R9 and R10: intrusion during a write must not alter the frames or fields
    run_op(5'h11, 5'h07, 16'h55AA, 2'd1, 16'h3C3C, 3'd0, 1'b0, 16'h0000, 1'b1, "R9 busy intrusion");

    k = 0;
    wr_reg(1'b1, cmd_word(1'b1, 3'd0, 1'b0, 2'd0, 16'h7777));
    rd_reg(1'b1, v);
    chk(v == 32'h0000_7777, "R11 null opcode completes at once", v, 32'h0000_7777);
    repeat (100) @(negedge clk);
    chk(k == 0 && mdc == 1'b0, "R11 null opcode no MDC", k, 0);

    chk(hi_glitch == 0, "R8 MDIO steady while MDC high", hi_glitch, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule